// File: doc/BRIEF.md
# Converter Result Two-Wire Target

This block is the two-wire serial (I2C) target port that stands in front of the result and configuration registers of a delta-sigma converter. It runs on an oversampled system clock, brings the raw SCL and SDA lines in through synchronizers, and pulls SDA low only through an output-enable, so the pad stays open-drain. It decodes the address byte and acknowledges only its own address.

On a read it returns the latest conversion result, sign-extended to whole bytes for the selected resolution, and then the configuration byte. The configuration byte repeats for as long as the controller keeps clocking. On a write it takes one configuration byte, which restarts the converter through a one-cycle start pulse. The configuration byte also carries a ready flag. This flag tells software whether a fresh result is still waiting to be read.

The converter core hands over each finished result through a data input and a valid strobe. It receives the current configuration and the start pulse in return.

Top module: `adc_i2c_target`

## Requirements
- R1: An address byte of binary 1101, then the three bits of parameter DEV_ADDR, then the R/W bit (1 = read), is acknowledged: the target pulls SDA low during the ninth clock. Write address 0xD0 and read address 0xD1 with DEV_ADDR = 0.
- R2: For any other address the target does not acknowledge. It keeps SDA released for every further clock until the next START.
- R3: With resolution code 11 (18-bit), a read returns three data bytes. The first is seven copies of D17 followed by D16. The second is D15..D8 and the third is D7..D0.
- R4: With resolution codes 00 (12-bit), 01 (14-bit) and 10 (16-bit), a read returns two data bytes: the result sign-extended to 16 bits, high byte first.
- R5: After the data bytes, every further byte the controller clocks holds the configuration byte.
- R6: The target stops driving SDA when the controller answers a byte with NAK (SDA high on the ninth clock), and on a STOP or a repeated START. After a repeated START the address is decoded again.
- R7: On a write, the first byte after the address becomes the configuration. Later bytes in the same transaction are acknowledged and have no effect on the configuration.
- R8: Taking a configuration byte raises `convStart` for exactly one clock. `cfgOut` updates on the same edge, three clock edges after the SCL fall that ends the eighth bit of that byte.
- R9: The ready flag is configuration bit 7. It reads 1 after reset and clears one edge after `resultValid`. It sets again when the last data byte of a read has been clocked out, as long as no newer result arrived in the meantime. A read that stops before the last data byte leaves it at 0.
- R10: Bits 3:2 of the configuration select the resolution. Bits 6:0 hold what was written and bit 7 of a written byte is ignored. After reset, `cfgOut` is 0x90.
- R11: The target changes its SDA drive only while SCL is low, apart from a release forced by STOP or START.
- R12: After reset, `sdaOe` and `convStart` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| resultIn | input | 18 | Conversion result, two's complement, right-aligned |
| resultValid | input | 1 | One-cycle strobe: resultIn holds a new result |
| cfgOut | output | 8 | Current configuration, ready flag in bit 7 |
| convStart | output | 1 | One-cycle pulse that starts a new conversion |

## Verification
Every bus event reaches the logic through two synchronizer flops and one edge register. A configuration update, the start pulse, the setting of the ready flag and every change of SDA drive therefore land three clock edges after the SCL edge that caused them. The ready flag clears one edge after `resultValid`. The bench keeps a behavioural model of the configuration and ready flag that it updates at the moment it moves SCL. It compares `cfgOut` on every clock, but skips six cycles after each model update so that it samples only where the design has already settled. SDA is read in the middle of the SCL high phase, long after the three-cycle drive latency.

// File: rtl/adci2c_pkg.sv
package adci2c_pkg;

  localparam int RES_W      = 18;
  localparam int BYTE_BITS  = 8;
  localparam int BIT_CNT_W  = $clog2(BYTE_BITS) + 1;
  localparam int IDX_W      = 2;
  localparam int CFG_W      = 7;
  localparam int EXT_W      = 24;
  localparam logic [3:0] DEV_CODE = 4'b1101;

  typedef enum logic [1:0] {
    RES12 = 2'b00,
    RES14 = 2'b01,
    RES16 = 2'b10,
    RES18 = 2'b11
  } resMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic             rxShift;
    logic             txLoad;
    logic             txShift;
    logic             snapshot;
    logic             cfgWrite;
    logic             dataDone;
    logic [IDX_W-1:0] byteIdx;
  } strobe_t;

endpackage

// File: rtl/adci2c_sync.sv
module adci2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] delayed;

  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) delayed <= '1;
    else       delayed <= synced;
  end

  logic sclD, sdaD;
  assign sclS = synced[1];
  assign sdaS = synced[0];
  assign sclD = delayed[1];
  assign sdaD = delayed[0];

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

endmodule

// File: rtl/adci2c_ctrl.sv
module adci2c_ctrl
  import adci2c_pkg::*;
#(
  parameter logic [2:0] DEV_ADDR = 3'b000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic [7:0]       rxByte,
  input  logic             txBit,
  input  logic [IDX_W-1:0] numData,
  output strobe_t          stb,
  output logic             sdaOe
);

  busState_t            state;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0]     rdIdx;
  logic [IDX_W-1:0]     nextIdx;
  logic                 isRead;
  logic                 wrFirst;
  logic                 ackDrive;
  logic                 addrHit;
  logic                 byteFull;
  logic                 lastRdBit;
  logic                 busEvent;

  assign addrHit   = (rxByte[7:1] == {DEV_CODE, DEV_ADDR});
  assign byteFull  = (bitCnt == BIT_CNT_W'(BYTE_BITS));
  assign lastRdBit = (bitCnt == BIT_CNT_W'(BYTE_BITS - 1));
  assign nextIdx   = (rdIdx < numData) ? rdIdx + 1'b1 : rdIdx;
  assign busEvent  = startDet | stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rdIdx    <= '0;
      isRead   <= 1'b0;
      wrFirst  <= 1'b0;
      ackDrive <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteFull) begin
            bitCnt <= '0;
            if (addrHit) begin
              state    <= ST_ADDR_ACK;
              ackDrive <= 1'b1;
              isRead   <= rxByte[0];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            rdIdx    <= '0;
            wrFirst  <= ~isRead;
            state    <= isRead ? ST_RD_BYTE : ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteFull) begin
            bitCnt   <= '0;
            state    <= ST_WR_ACK;
            ackDrive <= 1'b1;
            wrFirst  <= 1'b0;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            state    <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (lastRdBit) begin
              bitCnt <= '0;
              state  <= ST_RD_ACK;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise && sdaS) begin
            state <= ST_IGNORE;
          end else if (sclFall) begin
            rdIdx <= nextIdx;
            state <= ST_RD_BYTE;
          end
        end
        ST_IDLE, ST_IGNORE: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    if (!busEvent) begin
      unique case (state)
        ST_ADDR: begin
          stb.rxShift  = sclRise;
          stb.snapshot = sclFall & byteFull & addrHit & rxByte[0];
        end
        ST_ADDR_ACK: begin
          stb.txLoad  = sclFall & isRead;
          stb.byteIdx = '0;
        end
        ST_WR_BYTE: begin
          stb.rxShift  = sclRise;
          stb.cfgWrite = sclFall & byteFull & wrFirst;
        end
        ST_RD_BYTE: begin
          stb.txShift = sclFall & ~lastRdBit;
        end
        ST_RD_ACK: begin
          stb.dataDone = sclRise & (rdIdx == numData - 1'b1);
          stb.txLoad   = sclFall & ~sdaS;
          stb.byteIdx  = nextIdx;
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = ackDrive | ((state == ST_RD_BYTE) & ~txBit);

  // R11: drive level moves only while SCL is low, except a forced release
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet) && !$past(stopDet)) |-> !sclS);

  // R6: a NAK from the controller ends the drive for good
  p_nak_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_ACK && sclRise && sdaS && !busEvent) |=> (!sdaOe && state == ST_IGNORE));

  // R2: an unmatched address leaves the line released
  p_quiet_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteFull && !addrHit && !busEvent) |=> !sdaOe);

endmodule

// File: rtl/adci2c_dpath.sv
module adci2c_dpath
  import adci2c_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             sdaS,
  input  logic [RES_W-1:0] resultIn,
  input  logic             resultValid,
  output logic [7:0]       rxByte,
  output logic             txBit,
  output logic [IDX_W-1:0] numData,
  output logic [7:0]       cfgOut,
  output logic             convStart
);

  localparam logic [CFG_W-1:0] CFG_RESET = 7'h10;

  logic [7:0]       rxSh;
  logic [7:0]       txSh;
  logic [RES_W-1:0] resultReg;
  logic [RES_W-1:0] snapReg;
  resMode_t         snapMode;
  logic [CFG_W-1:0] cfgReg;
  logic             readyFlag;
  logic             gotNew;
  logic [EXT_W-1:0] extVal;
  logic [7:0]       loadByte;

  assign rxByte = rxSh;
  assign txBit  = txSh[7];
  assign cfgOut = {readyFlag, cfgReg};

  // sign extension of the snapshot for the resolution in force
  always_comb begin
    unique case (snapMode)
      RES12:   extVal = {{(EXT_W-12){snapReg[11]}}, snapReg[11:0]};
      RES14:   extVal = {{(EXT_W-14){snapReg[13]}}, snapReg[13:0]};
      RES16:   extVal = {{(EXT_W-16){snapReg[15]}}, snapReg[15:0]};
      default: extVal = {{(EXT_W-18){snapReg[17]}}, snapReg[17:0]};
    endcase
  end

  assign numData = (snapMode == RES18) ? IDX_W'(3) : IDX_W'(2);

  always_comb begin
    loadByte = {readyFlag, cfgReg};
    if (stb.byteIdx < numData) begin
      if (snapMode == RES18) begin
        unique case (stb.byteIdx)
          2'd0:    loadByte = extVal[23:16];
          2'd1:    loadByte = extVal[15:8];
          default: loadByte = extVal[7:0];
        endcase
      end else begin
        loadByte = (stb.byteIdx == '0) ? extVal[15:8] : extVal[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
      txSh <= '1;
    end else begin
      if (stb.rxShift) rxSh <= {rxSh[6:0], sdaS};
      if (stb.txLoad)       txSh <= loadByte;
      else if (stb.txShift) txSh <= {txSh[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      snapReg   <= '0;
      snapMode  <= RES12;
    end else begin
      if (resultValid) resultReg <= resultIn;
      if (stb.snapshot) begin
        snapReg  <= resultReg;
        snapMode <= resMode_t'(cfgReg[3:2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= CFG_RESET;
      convStart <= 1'b0;
    end else begin
      convStart <= stb.cfgWrite;
      if (stb.cfgWrite) cfgReg <= rxSh[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b1;
      gotNew    <= 1'b0;
    end else if (resultValid) begin
      readyFlag <= 1'b0;
      gotNew    <= 1'b1;
    end else begin
      if (stb.snapshot) gotNew <= 1'b0;
      if (stb.dataDone && !gotNew) readyFlag <= 1'b1;
    end
  end

  // R8: the configuration never moves without a start pulse
  p_cfg_change_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut[CFG_W-1:0]) |-> convStart);

  // R8: start is a single-cycle pulse
  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R9: a new result always clears the ready flag
  p_ready_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(resultValid) |-> !readyFlag);

endmodule

// File: rtl/adc_i2c_target.sv
module adc_i2c_target
  import adci2c_pkg::*;
#(
  parameter logic [2:0] DEV_ADDR    = 3'b000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [RES_W-1:0] resultIn,
  input  logic             resultValid,
  output logic [7:0]       cfgOut,
  output logic             convStart
);

  logic             sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [7:0]       rxByte;
  logic             txBit;
  logic [IDX_W-1:0] numData;
  strobe_t          stb;

  adci2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  adci2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txBit(txBit), .numData(numData), .stb(stb), .sdaOe(sdaOe)
  );

  adci2c_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS),
    .resultIn(resultIn), .resultValid(resultValid),
    .rxByte(rxByte), .txBit(txBit), .numData(numData),
    .cfgOut(cfgOut), .convStart(convStart)
  );

endmodule

// File: tb/adc_i2c_target_bench.sv
module adc_i2c_target_bench;

  localparam int H = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclDrv = 1'b1;
  logic        sdaDrv = 1'b1;
  logic        sdaOe;
  logic [17:0] resultIn = '0;
  logic        resultValid = 1'b0;
  logic [7:0]  cfgOut;
  logic        convStart;
  logic        sdaLine;

  always #2.5 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  adc_i2c_target u_adc_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .resultIn(resultIn), .resultValid(resultValid),
    .cfgOut(cfgOut), .convStart(convStart)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // behavioural model
  logic [6:0]  expCfg7 = 7'h10;
  logic        expReady = 1'b1;
  logic        expGotNew = 1'b0;
  logic [17:0] expResult = '0;
  logic [6:0]  nextCfg = '0;
  int          expPulses = 0;
  int          gotPulses = 0;
  int          holdoff = 0;
  bit          cmpOn = 0;
  bit          armCfg = 0;
  bit          armReady = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  // per-clock comparison of configuration and ready flag (R9, R10)
  always @(negedge clk) begin
    if (rstN && convStart) gotPulses++;
    if (holdoff > 0) holdoff--;
    else if (cmpOn) check(cfgOut == {expReady, expCfg7}, "R10/R9 cfgOut", 32'(cfgOut), 32'({expReady, expCfg7}));
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeBit(input logic b);
    sdaDrv = b;
    waitClk(H);
    sclDrv = 1'b1;
    if (armReady) begin
      if (!expGotNew) expReady = 1'b1;
      holdoff = 6;
      armReady = 0;
    end
    waitClk(H);
    sclDrv = 1'b0;
    if (armCfg) begin
      holdoff = 6;
      expCfg7 = nextCfg;
      expPulses++;
      armCfg = 0;
    end
    waitClk(4);
  endtask

  task automatic readBit(output logic b);
    sdaDrv = 1'b1;
    waitClk(H);
    sclDrv = 1'b1;
    waitClk(H / 2);
    b = sdaLine;
    waitClk(H / 2);
    sclDrv = 1'b0;
    waitClk(4);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1;
    waitClk(H);
    sclDrv = 1'b1;
    waitClk(H);
    sdaDrv = 1'b0;
    waitClk(H);
    sclDrv = 1'b0;
    waitClk(4);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0;
    waitClk(H);
    sclDrv = 1'b1;
    waitClk(H);
    sdaDrv = 1'b1;
    waitClk(H);
  endtask

  task automatic writeByte(input logic [7:0] b, input bit cfgHook, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && cfgHook) begin
        nextCfg = b[6:0];
        armCfg = 1;
      end
      writeBit(b[i]);
    end
    readBit(a);
    acked = ~a;
  endtask

  task automatic readByte(input bit nak, input bit lastData, output logic [7:0] got);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      readBit(a);
      got[i] = a;
    end
    armReady = lastData;
    writeBit(nak);
  endtask

  task automatic pushResult(input logic [17:0] v);
    resultIn = v;
    resultValid = 1'b1;
    expResult = v;
    expReady = 1'b0;
    expGotNew = 1'b1;
    holdoff = 4;
    waitClk(1);
    resultValid = 1'b0;
    waitClk(2);
  endtask

  function automatic logic [7:0] expByte(input logic [17:0] r, input logic [1:0] m, input int i);
    int n = 12 + 2 * int'(m);
    longint v = longint'(r) & ((64'sd1 <<< n) - 1);
    int nd = (m == 2'b11) ? 3 : 2;
    logic [23:0] w;
    if (v >= (64'sd1 <<< (n - 1))) v = v - (64'sd1 <<< n);
    w = 24'(v);
    return 8'(w >> (8 * (nd - 1 - i)));
  endfunction

  // body of a read after the START has been sent
  task automatic rdBody(input int nBytes, input string tagAck);
    bit ack;
    logic [7:0] got, want;
    logic [1:0] sMode = expCfg7[3:2];
    logic [17:0] sRes = expResult;
    int nd = (sMode == 2'b11) ? 3 : 2;
    logic b;
    expGotNew = 0;
    writeByte(8'hD1, 0, ack);
    check(ack, tagAck, 32'(ack), 1);
    for (int i = 0; i < nBytes; i++) begin
      want = (i < nd) ? expByte(sRes, sMode, i) : {expReady, expCfg7};
      readByte(i == nBytes - 1, i == nd - 1, got);
      if (i >= nd) check(got == want, "R5 repeated config byte", 32'(got), 32'(want));
      else if (sMode == 2'b11) check(got == want, "R3 18-bit data byte", 32'(got), 32'(want));
      else check(got == want, "R4 12/14/16-bit data byte", 32'(got), 32'(want));
    end
    check(sdaOe == 1'b0, "R6 released after NAK", 32'(sdaOe), 0);
    readBit(b);
    check(b == 1'b1, "R6 no drive after NAK", 32'(b), 1);
    stopCond();
  endtask

  task automatic rdTxn(input int nBytes);
    startCond();
    rdBody(nBytes, "R1 read address ACK");
  endtask

  task automatic wrTxn(input logic [7:0] cfg, input int nExtra);
    bit ack;
    startCond();
    writeByte(8'hD0, 0, ack);
    check(ack, "R1 write address ACK", 32'(ack), 1);
    writeByte(cfg, 1, ack);
    check(ack, "R7 config byte ACK", 32'(ack), 1);
    for (int i = 0; i < nExtra; i++) begin
      writeByte(8'h5A ^ 8'(i), 0, ack);
      check(ack, "R7 extra byte ACK", 32'(ack), 1);
    end
    stopCond();
    check(gotPulses == expPulses, "R8 start pulse count", 32'(gotPulses), 32'(expPulses));
  endtask

  initial begin
    bit ack;
    logic b;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R12 reset state
    check(sdaOe == 1'b0, "R12 sdaOe after reset", 32'(sdaOe), 0);
    check(convStart == 1'b0, "R12 convStart after reset", 32'(convStart), 0);
    check(cfgOut == 8'h90, "R10 cfgOut reset value", 32'(cfgOut), 32'h90);
    cmpOn = 1;

    // 18-bit mode, bit 7 of written byte ignored, one extra byte discarded (R7, R10)
    wrTxn(8'hFD, 1);
    pushResult(18'h2ABCD);
    rdTxn(5);

    // partial read keeps ready low, full read sets it (R9)
    pushResult(18'h1F00F);
    rdTxn(1);
    check(cfgOut[7] == 1'b0, "R9 ready stays low after partial read", 32'(cfgOut[7]), 0);
    rdTxn(4);
    check(cfgOut[7] == 1'b1, "R9 ready set after full read", 32'(cfgOut[7]), 1);

    // 16-bit mode
    wrTxn(8'h38, 0);
    pushResult(18'h38000);
    rdTxn(3);

    // 14-bit mode, two extra bytes
    wrTxn(8'h14, 2);
    pushResult(18'h02345);
    rdTxn(3);

    // 12-bit mode, positive and negative
    wrTxn(8'h10, 0);
    pushResult(18'h007FF);
    rdTxn(2);
    pushResult(18'h3F800);
    rdTxn(3);

    // wrong address: no ACK and no drive (R2)
    startCond();
    writeByte(8'hD2, 0, ack);
    check(!ack, "R2 no ACK for other address", 32'(ack), 0);
    for (int i = 0; i < 9; i++) begin
      readBit(b);
      check(b == 1'b1, "R2 line released", 32'(b), 1);
    end
    stopCond();

    // repeated START after a write address re-decodes (R6)
    pushResult(18'h00123);
    startCond();
    writeByte(8'hD0, 0, ack);
    check(ack, "R1 write address ACK before restart", 32'(ack), 1);
    startCond();
    rdBody(3, "R6 read address ACK after repeated START");

    waitClk(10);
    check(gotPulses == expPulses, "R8 final start pulse count", 32'(gotPulses), 32'(expPulses));
    summary();
  end

endmodule